// File: doc/BRIEF.md
# Configuration Image Checksum Generator

This block computes a 16-bit integrity word over a configuration image held in a small word-wide memory and stores the result back into the image's first word. A controller pulses `start` once the image is in place. The block then reads words 1 to 63 in turn through a read port whose data arrives one clock after the request. It folds each word into the running value one bit per clock, least significant bit first, and finally writes the value to address 0.

The update rule is not a plain polynomial XOR. For each bit, the register shifts left by one. The bit that enters is the low bit of a sum: the register shifted right by 1, the register shifted right by 14, the register shifted right by 15, the data bit, and a constant one. Only that low bit matters, so the entering bit equals the inverse of `crc[1] ^ crc[14] ^ crc[15] ^ data_bit`. Word 0 never takes part, because it is the word that receives the result.

Each run fetches one word and then takes sixteen bit steps per word, so a run lasts 63 × 16 clocks plus the one fetch cycle and one write cycle. The handshake consists of a busy level and a one-cycle done pulse.

Top module: `eeprom_csum_gen`

## Requirements
- R1: After reset, `busy`, `done`, `rd_en` and `wr_en` are low and `checksum` is 0.
- R2: A `start` sampled high while idle begins a run. In the next cycle `busy` is high, `rd_en` is high and `rd_addr` is 1. While idle, `rd_en` and `wr_en` stay low.
- R3: During a run, the block requests addresses 1, 2, …, 63 in ascending order, each exactly once, with no two requests on adjacent cycles. It expects `rd_data` for a request on the clock after the request.
- R4: The running value starts at 0 at every run. Bits are taken LSB first, 16 per word, word 1 first. Each bit updates the value as new = {old[14:0], s[0]}, where s = (old>>1) + (old>>14) + (old>>15) + bit + 1.
- R5: Word 0 is never read, and its contents have no effect on the result.
- R6: At the end of a run, `wr_en` is high for exactly one cycle with `wr_addr` = 0 and `wr_data` equal to the result. `checksum` shows the result and holds it while idle until the next start.
- R7: `done` is a one-cycle pulse in the same cycle as the write. It comes 1010 rising edges after the start, counting the edge that samples `start` as the first.
- R8: `busy` stays high from the cycle after the start through the `done` cycle, and is low in the cycle after `done`.
- R9: A `start` pulse while `busy` is high is ignored. The run keeps its read order, timing and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled while idle) |
| rd_en | output | 1 | Image read request |
| rd_addr | output | 6 | Image word address to read |
| rd_data | input | 16 | Word returned one clock after the request |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | 6 | Result write address (always 0) |
| wr_data | output | 16 | Result word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| checksum | output | 16 | Running, then final, checksum value |

## Verification
The bench targets the bit order at the edges of the image. A single set bit in word 1 bit 0, or in word 63 bit 15, shows whether a design reverses the bit order inside words or drops the first or last bit: the result would differ from the arithmetic model. It rewrites word 0 between runs, which exposes a design that folds word 0 in or reads it. It also checks that the register is cleared at each start, since a design that kept the old value would give a different second result. A start pulse injected mid-run catches a design that restarts, which would shift the `done` cycle and disturb the read sequence.

// File: rtl/eeprom_csum_pkg.sv
package eeprom_csum_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_RUN    = 2'd2,
        ST_FINISH = 2'd3
    } csum_state_e;

endpackage

// File: rtl/eeprom_csum_step.sv
module eeprom_csum_step #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] crc_in,
    input  logic              data_bit,
    output logic [WORD_W-1:0] crc_out
);
    // low bit of (c>>1)+(c>>14)+(c>>15)+bit+1 is the inverted parity of those bits
    logic feedback;

    always_comb begin
        feedback = ~(crc_in[1] ^ crc_in[WORD_W-2] ^ crc_in[WORD_W-1] ^ data_bit);
        crc_out  = {crc_in[WORD_W-2:0], feedback};
    end
endmodule

// File: rtl/eeprom_csum_bitsrc.sv
module eeprom_csum_bitsrc #(
    parameter int WORD_W = 16
) (
    input  logic              first_bit,
    input  logic [WORD_W-1:0] fresh_word,
    input  logic [WORD_W-1:0] shreg_in,
    output logic              data_bit,
    output logic [WORD_W-1:0] shreg_out
);
    // bit 0 of a new word comes straight from the read port, the rest from the shifter
    always_comb begin
        if (first_bit) begin
            data_bit  = fresh_word[0];
            shreg_out = fresh_word >> 1;
        end else begin
            data_bit  = shreg_in[0];
            shreg_out = shreg_in >> 1;
        end
    end
endmodule

// File: rtl/eeprom_csum_gen.sv
module eeprom_csum_gen
    import eeprom_csum_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 64,
    localparam int ADDR_W   = $clog2(NUM_WORDS),
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] checksum
);
    localparam logic [ADDR_W-1:0] FIRST_WORD = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] LAST_WORD  = ADDR_W'(NUM_WORDS - 1);
    localparam logic [BIT_W-1:0]  LAST_BIT   = BIT_W'(WORD_W - 1);

    typedef struct packed {
        csum_state_e       st;
        logic [ADDR_W-1:0] word;
        logic [BIT_W-1:0]  bitc;
        logic [WORD_W-1:0] shreg;
        logic [WORD_W-1:0] crc;
    } csum_regs_t;

    csum_regs_t regs_q, regs_d;

    logic              first_bit;
    logic              data_bit;
    logic [WORD_W-1:0] shreg_next;
    logic [WORD_W-1:0] crc_next;
    logic              rd_en_d;
    logic [ADDR_W-1:0] rd_addr_d;

    assign first_bit = (regs_q.st == ST_RUN) && (regs_q.bitc == '0);

    eeprom_csum_bitsrc #(.WORD_W(WORD_W)) u_bitsrc (
        .first_bit  (first_bit),
        .fresh_word (rd_data),
        .shreg_in   (regs_q.shreg),
        .data_bit   (data_bit),
        .shreg_out  (shreg_next)
    );

    eeprom_csum_step #(.WORD_W(WORD_W)) u_step (
        .crc_in   (regs_q.crc),
        .data_bit (data_bit),
        .crc_out  (crc_next)
    );

    always_comb begin
        regs_d    = regs_q;
        rd_en_d   = 1'b0;
        rd_addr_d = regs_q.word;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (start) begin
                    regs_d.st   = ST_FETCH;
                    regs_d.word = FIRST_WORD;
                    regs_d.bitc = '0;
                    regs_d.crc  = '0;
                end
            end
            ST_FETCH: begin
                rd_en_d     = 1'b1;
                rd_addr_d   = regs_q.word;
                regs_d.st   = ST_RUN;
                regs_d.bitc = '0;
            end
            ST_RUN: begin
                regs_d.crc   = crc_next;
                regs_d.shreg = shreg_next;
                regs_d.bitc  = regs_q.bitc + BIT_W'(1);
                if (regs_q.bitc == LAST_BIT) begin
                    regs_d.bitc = '0;
                    if (regs_q.word == LAST_WORD) begin
                        regs_d.st = ST_FINISH;
                    end else begin
                        rd_en_d     = 1'b1;
                        rd_addr_d   = regs_q.word + ADDR_W'(1);
                        regs_d.word = regs_q.word + ADDR_W'(1);
                    end
                end
            end
            ST_FINISH: begin
                regs_d.st = ST_IDLE;
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_IDLE, word: '0, bitc: '0, shreg: '0, crc: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_en    = rd_en_d;
    assign rd_addr  = rd_addr_d;
    assign busy     = (regs_q.st != ST_IDLE);
    assign done     = (regs_q.st == ST_FINISH);
    assign wr_en    = done;
    assign wr_addr  = '0;
    assign wr_data  = regs_q.crc;
    assign checksum = regs_q.crc;

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd_en && !wr_en));

    assert_read_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    assert_no_word0_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_addr != '0));

    assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(checksum));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/eeprom_csum_gen_test.sv
`timescale 1ns/1ps
module eeprom_csum_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_en;
    logic [5:0]  rd_addr;
    logic [15:0] rd_data = '0;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [15:0] wr_data;
    logic        busy;
    logic        done;
    logic [15:0] checksum;

    logic [15:0] mem [64];
    int checks = 0;
    int errors = 0;
    int rd_seq = 0;
    int rd_bad = 0;
    logic [15:0] saved;

    always #2 clk = ~clk;

    eeprom_csum_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .checksum(checksum)
    );

    // image memory with one-clock read latency
    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // read order monitor (R3, R5)
    always @(negedge clk) begin
        if (rst_n && rd_en) begin
            if (int'(rd_addr) != rd_seq) rd_bad++;
            rd_seq++;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model();
        logic [15:0] c = '0;
        for (int w = 1; w < 64; w++) begin
            logic [15:0] d = mem[w];
            for (int j = 0; j < 16; j++) begin
                int s = int'(c >> 1) + int'(c >> 14) + int'(c >> 15) + int'(d[j]) + 1;
                c = {c[14:0], s[0]};
            end
        end
        return c;
    endfunction

    task automatic run(input string tag, input int poke_at, output logic [15:0] got);
        logic [15:0] exp = model();
        int n = 0;
        rd_seq = 1;
        rd_bad = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        n = 1;
        check(busy && rd_en && rd_addr == 6'd1, "R2", {busy, rd_en, rd_addr}, {1'b1, 1'b1, 6'd1});
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
            if (n == poke_at) start = 1'b1;
            else start = 1'b0;
            if (!done) check(busy, "R8", busy, 1);
        end
        start = 1'b0;
        check(n == 1010, {"R7 ", tag}, n, 1010);
        check(wr_en && wr_addr == 0 && wr_data == exp, {"R6 ", tag}, wr_data, exp);
        check(checksum == exp, {"R4 ", tag}, checksum, exp);
        check(rd_seq == 64 && rd_bad == 0, {"R3 ", tag}, rd_seq, 64);
        @(negedge clk);
        check(!done && !busy && !wr_en, "R8 R7", {done, busy, wr_en}, 0);
        check(mem[0] == exp && checksum == exp, "R6 hold", mem[0], exp);
        got = checksum;
    endtask

    initial begin
        #300000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [31:0] lcg;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && !rd_en && !wr_en && checksum == 0, "R1",
              {busy, done, rd_en, wr_en, checksum}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy && !rd_en && !wr_en, "R2 idle", {busy, rd_en, wr_en}, 0);

        run("zeros", 0, r);
        for (int i = 1; i < 64; i++) mem[i] = 16'hffff;
        run("ones", 0, r);
        for (int i = 1; i < 64; i++) mem[i] = 16'(i * 16'h0101);
        run("ramp", 0, r);
        for (int i = 1; i < 64; i++) mem[i] = '0;
        mem[1] = 16'h0001;
        run("first bit", 0, r);
        mem[1] = '0;
        mem[63] = 16'h8000;
        run("last bit", 0, r);

        lcg = 32'h1234_5678;
        for (int i = 1; i < 64; i++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            mem[i] = lcg[31:16];
        end
        // R5: word 0 contents do not matter; R4: register cleared each run
        mem[0] = 16'hdead;
        run("random", 0, r);
        saved = r;
        mem[0] = 16'h5a5a;
        run("R5 word0 changed", 0, r);
        check(r == saved, "R5", r, saved);
        // R9: start mid-run is ignored
        run("R9 start while busy", 500, r);
        check(r == saved, "R9", r, saved);
        repeat (4) @(negedge clk);
        check(checksum == saved && !busy, "R6 idle hold", checksum, saved);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule